// File: doc/BRIEF.md
# GPIO Input Change Interrupt Controller

This block watches a set of general-purpose port inputs (nine by default) and tells a host when any of them has moved away from the value the host last saw. Every port keeps a snapshot of its input, taken when the host reads that port. While a port is configured as an input, the block compares the live value with the snapshot on every clock. A mismatch raises the port's transition flag. The value compared is either the raw pin or, when filtering is selected for that port, an already-debounced copy supplied from outside.

Ports whose interrupt enable is set drive a single interrupt line. The host clears that line by reading the device status register, then reads the flagged port registers to clear their flags. A read transaction is marked by bus START and STOP indications. While one is open, the interrupt line does not rise. A qualifying change seen during the transaction is parked and released at STOP, unless the host read the changed port before STOP. A hardware reset ends any transaction and re-arms the snapshots, but leaves the interrupt line as it was.

Top module: `gpio_chg_irq`

## Requirements
- R1: After `rst_n` is held low for a clock edge, `irq`, `stat_irq`, `glob_trans` and every bit of `trans_flags` are 0, and every snapshot holds 0.
- R2: For an input port, the compared value differing from the snapshot at a clock edge sets that port's `trans_flags` bit after that edge. The bit stays set even if the input returns to the snapshot value, until the port is read.
- R3: When `deb_en[i]` is 1, port i compares `deb_in[i]` and ignores `pin_in[i]`. When it is 0, port i compares `pin_in[i]`.
- R4: A port with `dir_in[i]` = 0 (output; 1 means input) never sets its transition flag, whatever its inputs do.
- R5: A cycle with `rd_port` high and `rd_idx` = i, where i is below the port count, copies port i's compared value into its snapshot and clears `trans_flags[i]` after that edge. An `rd_idx` at or above the port count changes nothing.
- R6: `glob_trans` is 1 while any transition flag is set. It returns to 0 only once every flagged port has been read.
- R7: Outside a transaction, a flag going from 0 to 1 on a port with `int_en[i]` = 1 sets `irq` after the same edge. Flags on ports with `int_en[i]` = 0 never raise `irq`.
- R8: A cycle with `rd_stat` high clears `irq` after that edge, unless a new qualifying event occurs in the same cycle. Transition flags are not affected.
- R9: From the cycle `bus_start` is high until the cycle `bus_stop` is high, `irq` does not rise. A qualifying event in that window raises `irq` after the `bus_stop` edge, unless that port was read before or at STOP.
- R10: `stat_irq` equals `irq` at all times.
- R11: A cycle with `hw_rst` high ends any open transaction, drops parked events, re-captures every snapshot and clears every flag. `irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low; clears all state |
| hw_rst | input | 1 | Hardware reset request; re-arms ports and leaves the interrupt alone |
| pin_in | input | NPORT | Raw synchronized port inputs |
| deb_in | input | NPORT | Debounced port inputs from the external filter |
| deb_en | input | NPORT | Per-port select of the debounced input |
| dir_in | input | NPORT | Per-port direction, 1 = input, 0 = output |
| int_en | input | NPORT | Per-port interrupt enable |
| rd_port | input | 1 | Port register read strobe |
| rd_idx | input | IDXW | Index of the port being read |
| rd_stat | input | 1 | Device status register read strobe |
| bus_start | input | 1 | Bus START seen |
| bus_stop | input | 1 | Bus STOP seen |
| irq | output | 1 | Interrupt, active high |
| stat_irq | output | 1 | Interrupt bit of the status register |
| glob_trans | output | 1 | Any port has an unread transition |
| trans_flags | output | NPORT | Per-port transition flags |

## Verification
A stuck or wrongly cleared snapshot shows up as a flag that rises with no input movement, or that fails to rise, one edge after the port read or input change that exposes it. A lost or leaked parked event shows up on `irq` at the edge that samples `bus_stop`. It appears either as a missing rise, or as a rise after the changed port was already read. A transaction-state error shows up as `irq` rising inside the START/STOP window in the very cycle the change lands. A wrong reset scope shows as `irq` dropping, or flags surviving, right after the `hw_rst` edge.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  // value a port compares against its snapshot
  function automatic logic sel_src(logic use_deb, logic raw, logic deb);
    return use_deb ? deb : raw;
  endfunction

  // a port counts as changed only when it is an input and differs
  function automatic logic is_delta(logic is_in, logic cur, logic snap);
    return is_in & (cur ^ snap);
  endfunction

endpackage

// File: rtl/gpio_chg_lane.sv
module gpio_chg_lane
  import gpio_chg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic raw,
  input  logic deb,
  input  logic use_deb,
  input  logic is_in,
  input  logic int_en,
  input  logic rd_hit,
  input  logic hold,
  input  logic txn_end,
  output logic tflag,
  output logic imm_ev,
  output logic rel_ev
);

  logic snap;
  logic pend;
  logic cur;
  logic delta;
  logic first_ev;

  assign cur      = sel_src(use_deb, raw, deb);
  assign delta    = is_delta(is_in, cur, snap);
  assign first_ev = delta & ~tflag & ~rd_hit & ~hw_rst & int_en;
  assign imm_ev   = first_ev & ~hold;
  assign rel_ev   = pend & ~rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap  <= 1'b0;
      tflag <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (hw_rst || rd_hit) begin
        snap  <= cur;
        tflag <= 1'b0;
      end else begin
        tflag <= tflag | delta;
      end
      if (hw_rst || rd_hit || txn_end)
        pend <= 1'b0;
      else if (hold && first_ev)
        pend <= 1'b1;
    end
  end

endmodule

// File: rtl/gpio_chg_ctl.sv
module gpio_chg_ctl #(
  parameter int NPORT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             rd_stat,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [NPORT-1:0] imm_ev,
  input  logic [NPORT-1:0] rel_ev,
  output logic             hold,
  output logic             txn_end,
  output logic             fire,
  output logic             irq
);

  logic in_txn;

  assign hold    = (in_txn | bus_start) & ~bus_stop;
  assign txn_end = bus_stop;
  assign fire    = ~hw_rst & ((|imm_ev) | (bus_stop & in_txn & (|rel_ev)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_txn <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (hw_rst || bus_stop)
        in_txn <= 1'b0;
      else if (bus_start)
        in_txn <= 1'b1;
      irq <= (irq & ~rd_stat) | fire;
    end
  end

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int NPORT = 9,
  parameter int IDXW  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic [NPORT-1:0] pin_in,
  input  logic [NPORT-1:0] deb_in,
  input  logic [NPORT-1:0] deb_en,
  input  logic [NPORT-1:0] dir_in,
  input  logic [NPORT-1:0] int_en,
  input  logic             rd_port,
  input  logic [IDXW-1:0]  rd_idx,
  input  logic             rd_stat,
  input  logic             bus_start,
  input  logic             bus_stop,
  output logic             irq,
  output logic             stat_irq,
  output logic             glob_trans,
  output logic [NPORT-1:0] trans_flags
);

  logic [NPORT-1:0] rd_hit;
  logic [NPORT-1:0] imm_ev;
  logic [NPORT-1:0] rel_ev;
  logic             hold_w;
  logic             txn_end_w;
  logic             fire_w;

  for (genvar g = 0; g < NPORT; g++) begin : g_lane
    assign rd_hit[g] = rd_port && (rd_idx == IDXW'(g));
    gpio_chg_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_rst  (hw_rst),
      .raw     (pin_in[g]),
      .deb     (deb_in[g]),
      .use_deb (deb_en[g]),
      .is_in   (dir_in[g]),
      .int_en  (int_en[g]),
      .rd_hit  (rd_hit[g]),
      .hold    (hold_w),
      .txn_end (txn_end_w),
      .tflag   (trans_flags[g]),
      .imm_ev  (imm_ev[g]),
      .rel_ev  (rel_ev[g])
    );
  end

  gpio_chg_ctl #(.NPORT(NPORT)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_rst    (hw_rst),
    .rd_stat   (rd_stat),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .imm_ev    (imm_ev),
    .rel_ev    (rel_ev),
    .hold      (hold_w),
    .txn_end   (txn_end_w),
    .fire      (fire_w),
    .irq       (irq)
  );

  assign stat_irq   = irq;
  assign glob_trans = |trans_flags;

endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk #(
  parameter int NPORT = 9,
  parameter int IDXW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_rst,
  input logic [NPORT-1:0] dir_in,
  input logic             rd_port,
  input logic [IDXW-1:0]  rd_idx,
  input logic             rd_stat,
  input logic             irq,
  input logic [NPORT-1:0] trans_flags,
  input logic             hold_w,
  input logic             fire_w
);

  // R4: output ports never raise a flag
  a_r4_no_out_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_flags & ~$past(trans_flags) & ~$past(dir_in)) == '0);

  // R5: a valid port read leaves that port's flag clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_port && (int'(rd_idx) < NPORT)) |=> !trans_flags[$past(rd_idx)]);

  // R8: status read drops the interrupt when nothing new fires
  a_r8_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !fire_w) |=> !irq);

  // R9: interrupt never rises out of a held transaction cycle
  a_r9_no_rise_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(hold_w));

  // R11: hardware reset leaves the interrupt as it was
  a_r11_hw_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst && !rd_stat) |=> (irq == $past(irq)));

endmodule

bind gpio_chg_irq gpio_chg_chk #(.NPORT(NPORT), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_rst      (hw_rst),
  .dir_in      (dir_in),
  .rd_port     (rd_port),
  .rd_idx      (rd_idx),
  .rd_stat     (rd_stat),
  .irq         (irq),
  .trans_flags (trans_flags),
  .hold_w      (hold_w),
  .fire_w      (fire_w)
);

// File: tb/sim_gpio_chg_irq.sv
module sim_gpio_chg_irq;
  localparam int N = 9;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hw_rst, rd_port, rd_stat, bus_start, bus_stop;
  logic [N-1:0] pin_in, deb_in, deb_en, dir_in, int_en;
  logic [W-1:0] rd_idx;
  logic irq, stat_irq, glob_trans;
  logic [N-1:0] trans_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_chg_irq #(.NPORT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pin_in(pin_in), .deb_in(deb_in),
    .deb_en(deb_en), .dir_in(dir_in), .int_en(int_en), .rd_port(rd_port),
    .rd_idx(rd_idx), .rd_stat(rd_stat), .bus_start(bus_start), .bus_stop(bus_stop),
    .irq(irq), .stat_irq(stat_irq), .glob_trans(glob_trans), .trans_flags(trans_flags)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rdp(int i);
    rd_port = 1'b1;
    rd_idx  = W'(i);
    tick();
    rd_port = 1'b0;
  endtask

  task automatic rds();
    rd_stat = 1'b1;
    tick();
    rd_stat = 1'b0;
  endtask

  task automatic pulse_start();
    bus_start = 1'b1; tick(); bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hw_rst = 1'b0; rd_port = 1'b0; rd_stat = 1'b0;
    bus_start = 1'b0; bus_stop = 1'b0; rd_idx = '0;
    pin_in = '0; deb_in = '0; deb_en = '0; dir_in = '1; int_en = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 stat_irq", {31'd0, stat_irq}, 0);
    chk("R1 glob_trans", {31'd0, glob_trans}, 0);
    chk("R1 flags (snapshots zero)", 32'(trans_flags), 0);

    // sweep every port: set, status read, port read
    for (int i = 0; i < N; i++) begin
      pin_in[i] = 1'b1;
      tick();
      chk("R2 flag set", 32'(trans_flags), 32'(1) << i);
      chk("R7 irq raised", {31'd0, irq}, 1);
      chk("R10 stat_irq matches", {31'd0, stat_irq}, {31'd0, irq});
      chk("R6 glob set", {31'd0, glob_trans}, 1);
      rds();
      chk("R8 irq cleared", {31'd0, irq}, 0);
      chk("R8 flag kept", 32'(trans_flags), 32'(1) << i);
      rdp(i);
      chk("R5 flag cleared", 32'(trans_flags), 0);
      chk("R6 glob clear", {31'd0, glob_trans}, 0);
    end

    // R4 outputs never flag
    dir_in = '0;
    pin_in = '0;
    tick(); tick();
    chk("R4 no flag on outputs", 32'(trans_flags), 0);
    chk("R4 no irq on outputs", {31'd0, irq}, 0);
    pin_in = '1;
    tick();
    dir_in = '1;
    tick();
    chk("R4 restored quiet", 32'(trans_flags), 0);

    // R7 disabled port flags but no irq
    int_en = '0;
    pin_in[3] = 1'b0;
    tick();
    chk("R7 flag without enable", 32'(trans_flags), 32'(1) << 3);
    chk("R7 no irq without enable", {31'd0, irq}, 0);
    rdp(3);
    int_en = '1;
    chk("R5 flag 3 cleared", 32'(trans_flags), 0);

    // R3 debounce source select
    deb_en[5] = 1'b1;
    deb_in[5] = 1'b1;
    pin_in[5] = 1'b0;
    tick(); tick();
    chk("R3 raw ignored", 32'(trans_flags), 0);
    deb_in[5] = 1'b0;
    tick();
    chk("R3 debounced change", 32'(trans_flags), 32'(1) << 5);
    chk("R3 irq", {31'd0, irq}, 1);
    rds();
    rdp(5);
    deb_en[5] = 1'b0;
    tick();
    chk("R3 back to raw", 32'(trans_flags), 0);

    // R2 sticky flag
    pin_in[0] = 1'b0;
    tick();
    pin_in[0] = 1'b1;
    tick();
    chk("R2 sticky", 32'(trans_flags), 1);
    rds();
    rdp(0);
    chk("R2 cleared by read", 32'(trans_flags), 0);

    // R5 out-of-range index
    pin_in[1] = 1'b0;
    tick();
    rdp(9);
    chk("R5 bad index ignored", 32'(trans_flags), 32'(1) << 1);
    rds();
    rdp(1);

    // R6 global flag needs all reads
    pin_in[2] = 1'b0;
    pin_in[4] = 1'b0;
    tick();
    chk("R6 two flags", 32'(trans_flags), 32'h14);
    rds();
    rdp(2);
    chk("R6 glob after one read", {31'd0, glob_trans}, 1);
    rdp(4);
    chk("R6 glob after all read", {31'd0, glob_trans}, 0);

    // R9 held until STOP
    pulse_start();
    pin_in[6] = 1'b0;
    tick();
    chk("R9 flag in txn", 32'(trans_flags), 32'(1) << 6);
    chk("R9 irq held", {31'd0, irq}, 0);
    tick();
    chk("R9 irq still held", {31'd0, irq}, 0);
    pulse_stop();
    chk("R9 irq at stop", {31'd0, irq}, 1);
    rds();
    rdp(6);

    // R9 dropped when read before STOP
    pulse_start();
    pin_in[7] = 1'b0;
    tick();
    chk("R9 irq held 2", {31'd0, irq}, 0);
    rdp(7);
    chk("R9 flag read", 32'(trans_flags), 0);
    pulse_stop();
    chk("R9 dropped after read", {31'd0, irq}, 0);

    // R11 hardware reset
    pin_in[8] = 1'b0;
    tick();
    chk("R11 pre irq", {31'd0, irq}, 1);
    hw_rst = 1'b1; tick(); hw_rst = 1'b0;
    chk("R11 irq kept", {31'd0, irq}, 1);
    chk("R11 flags cleared", 32'(trans_flags), 0);
    tick();
    chk("R11 snapshot recaptured", 32'(trans_flags), 0);
    rds();
    chk("R8 clear after hw", {31'd0, irq}, 0);
    pulse_start();
    pin_in[8] = 1'b1;
    tick();
    hw_rst = 1'b1; tick(); hw_rst = 1'b0;
    pulse_stop();
    chk("R11 parked event dropped", {31'd0, irq}, 0);
    chk("R11 flags after drop", 32'(trans_flags), 0);
    chk("R10 final match", {31'd0, stat_irq}, {31'd0, irq});

    finish_run();
  end
endmodule